// File: doc/BRIEF.md
# Floppy Control Port Decoder

This block is the write side of a small parallel-port style register set that steers a floppy disk controller. It has four byte locations on a 2-bit address: two read-only switch banks that hold board configuration, one command byte whose bits control the disk controller, and a mode location. Before any command byte is accepted, software must write the single supported mode word. Any other mode word is refused and flagged.

Each accepted command byte is stored and decoded at once. Some bits are active high and some are active low. The terminal-count bit, the cleared ready bit and the controller-reset bit each produce a one-clock action strobe in the cycle after the write. The strobe fires again on every write that qualifies, not only on a change of the bit. The interrupt-enable bit is held as a level. The two active-low drive-select bits are resolved into a drive number, and drive 0 has priority. The motor and precompensation bits are stored only.

Top module: `fdc_port_ctl`

## Requirements
- R1: After reset, the mode word and the command byte both read as 0x00. All strobes are low, `irq_en` is 0, `drive_sel` is 0, `mode_ok` is 0 and `mode_err` is 0.
- R2: A write of 0x92 to address 3 (mode) is accepted. From the next cycle `mode_ok` is 1, `mode_err` is 0, and a read of address 3 returns 0x92.
- R3: A write of any other value to address 3 sets `mode_err` to 1 from the next cycle. It leaves the stored mode word and `mode_ok` unchanged. A later accepted mode write clears `mode_err`.
- R4: While `mode_ok` is 0, writes to address 2 (command) are ignored. No strobe fires and the command byte keeps its value.
- R5: An accepted command write with bit 0 (terminal count, active high) set raises `finish_stb` for exactly the one cycle after the write. Back-to-back qualifying writes give back-to-back strobe cycles.
- R6: An accepted command write with bit 1 (ready, active high) equal to 0 raises `abort_stb` for the one cycle after the write.
- R7: An accepted command write with bit 7 (controller reset, active high) set raises `fdc_reset_stb` for the one cycle after the write.
- R8: `irq_en` follows bit 2 of the stored command byte as a level.
- R9: Bits 3 and 4 are active-low selects for drive 0 and drive 1. `drive_sel` is 0 when bit 3 is low, whatever bit 4 is. It is 1 when bit 3 is high and bit 4 is low. It is 0 when both are high.
- R10: Bits 5 (motor on, active low) and 6 (precompensation, active low) are stored and read back at address 2. They cause no strobe and change no other output.
- R11: With `rd_en` high, address 0 returns switch bank A (default 0xE7), address 1 returns bank B (default 0xF8), address 2 returns the command byte and address 3 returns the mode word. With `rd_en` low, `rdata` is 0x00.
- R12: Writes to addresses 0 and 1 have no effect on any stored state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 2 | Byte select: 0 bank A, 1 bank B, 2 command, 3 mode |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from `addr` |
| finish_stb | output | 1 | One-cycle terminal-count action |
| abort_stb | output | 1 | One-cycle abort action |
| fdc_reset_stb | output | 1 | One-cycle controller-reset action |
| irq_en | output | 1 | Disk interrupt enable level |
| drive_sel | output | 1 | Selected drive number |
| mode_ok | output | 1 | Supported mode word is in place |
| mode_err | output | 1 | Last mode write was refused |

## Verification
The assertions assume that `wr_en` and `rd_en` are plain one-cycle bus strobes, sampled on the rising edge. They also assume that no write arrives during the two cycles in which the internal reset is still being released. A write there is dropped, but the properties are keyed to the external reset. The stimulus waits well past reset release before the first access. It changes `addr`, `wdata` and the strobes only on the falling edge, so every write is seen at exactly one rising edge.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;
  typedef enum logic [1:0] {
    PORT_SWA  = 2'd0,
    PORT_SWB  = 2'd1,
    PORT_CMD  = 2'd2,
    PORT_MODE = 2'd3
  } port_sel_e;

  localparam logic [7:0] MODE_ACCEPT = 8'h92;

  localparam int B_TC    = 0;
  localparam int B_RDY   = 1;
  localparam int B_IE    = 2;
  localparam int B_SEL0N = 3;
  localparam int B_SEL1N = 4;
  localparam int B_MOTN  = 5;
  localparam int B_PCMPN = 6;
  localparam int B_FRES  = 7;

  typedef struct packed {
    logic finish;
    logic abort;
    logic ctl_reset;
  } fdc_stb_t;
endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fdc_mode_reg.sv
module fdc_mode_reg
  import fdc_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic          mode_ok,
  output logic          mode_err
);
  localparam logic [DW-1:0] ACCEPT = DW'(MODE_ACCEPT);

  logic [DW-1:0] mode_d;
  logic          err_d, err_q;
  logic          mode_en;

  always_comb begin
    mode_d  = mode_q;
    err_d   = err_q;
    mode_en = 1'b0;
    if (wr_mode) begin
      if (wdata == ACCEPT) begin
        mode_d  = wdata;
        mode_en = 1'b1;
        err_d   = 1'b0;
      end else begin
        err_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (wr_mode) err_q  <= err_d;
    end
  end

  assign mode_ok  = (mode_q == ACCEPT);
  assign mode_err = err_q;
endmodule

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output fdc_stb_t      stb_q,
  output logic          irq_en,
  output logic          drive_sel
);
  logic [DW-1:0] cmd_d;
  fdc_stb_t      stb_d;

  always_comb begin
    cmd_d           = wr_cmd ? wdata : cmd_q;
    stb_d.finish    = wr_cmd &&  wdata[B_TC];
    stb_d.abort     = wr_cmd && !wdata[B_RDY];
    stb_d.ctl_reset = wr_cmd &&  wdata[B_FRES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      stb_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= cmd_d;
      stb_q <= stb_d;
    end
  end

  always_comb begin
    if (!cmd_q[B_SEL0N])      drive_sel = 1'b0;
    else if (!cmd_q[B_SEL1N]) drive_sel = 1'b1;
    else                      drive_sel = 1'b0;
  end

  assign irq_en = cmd_q[B_IE];
endmodule

// File: rtl/fdc_rd_mux.sv
module fdc_rd_mux
  import fdc_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] swa,
  input  logic [DW-1:0] swb,
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] mode,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (port_sel_e'(addr))
        PORT_SWA:  rdata = swa;
        PORT_SWB:  rdata = swb;
        PORT_CMD:  rdata = cmd;
        PORT_MODE: rdata = mode;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fdc_port_ctl.sv
module fdc_port_ctl
  import fdc_ctl_pkg::*;
#(
  parameter int         DW       = 8,
  parameter int         AW       = 2,
  parameter logic [7:0] SWA_INIT = 8'hE7,
  parameter logic [7:0] SWB_INIT = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          finish_stb,
  output logic          abort_stb,
  output logic          fdc_reset_stb,
  output logic          irq_en,
  output logic          drive_sel,
  output logic          mode_ok,
  output logic          mode_err
);
  logic          rst_i_n;
  logic          wr_mode, wr_cmd;
  logic [DW-1:0] mode_q, cmd_q;
  fdc_stb_t      stb_q;

  fdc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign wr_mode = wr_en && (port_sel_e'(addr[1:0]) == PORT_MODE);
  assign wr_cmd  = wr_en && (port_sel_e'(addr[1:0]) == PORT_CMD) && mode_ok;

  fdc_mode_reg #(.DW(DW)) u_mode (
    .clk(clk), .rst_n(rst_i_n), .wr_mode(wr_mode), .wdata(wdata),
    .mode_q(mode_q), .mode_ok(mode_ok), .mode_err(mode_err)
  );

  fdc_cmd_decode #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_i_n), .wr_cmd(wr_cmd), .wdata(wdata),
    .cmd_q(cmd_q), .stb_q(stb_q), .irq_en(irq_en), .drive_sel(drive_sel)
  );

  fdc_rd_mux #(.DW(DW)) u_rd (
    .rd_en(rd_en), .addr(addr[1:0]),
    .swa(DW'(SWA_INIT)), .swb(DW'(SWB_INIT)),
    .cmd(cmd_q), .mode(mode_q), .rdata(rdata)
  );

  assign finish_stb    = stb_q.finish;
  assign abort_stb     = stb_q.abort;
  assign fdc_reset_stb = stb_q.ctl_reset;
endmodule

// File: rtl/fdc_port_ctl_chk.sv
module fdc_port_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       finish_stb,
  input logic       abort_stb,
  input logic       fdc_reset_stb,
  input logic       drive_sel,
  input logic       mode_ok,
  input logic       mode_err
);
  assert_finish_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_stb |-> $past(wr_en && addr == 2'd2 && wdata[0] && mode_ok));

  assert_abort_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |-> $past(wr_en && addr == 2'd2 && !wdata[1] && mode_ok));

  assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_reset_stb |-> $past(wr_en && addr == 2'd2 && wdata[7] && mode_ok));

  assert_bad_mode_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata != 8'h92) |=> (mode_err && $stable(mode_ok)));

  assert_good_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata == 8'h92) |=> (mode_ok && !mode_err));

  assert_premode_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !mode_ok) |=> !(finish_stb || abort_stb || fdc_reset_stb));

  assert_drive0_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && mode_ok && !wdata[3]) |=> !drive_sel);
endmodule

bind fdc_port_ctl fdc_port_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .finish_stb(finish_stb), .abort_stb(abort_stb), .fdc_reset_stb(fdc_reset_stb),
  .drive_sel(drive_sel), .mode_ok(mode_ok), .mode_err(mode_err)
);

// File: tb/sim_fdc_port_ctl.sv
module sim_fdc_port_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       wr_en, rd_en;
  logic [7:0] rdata;
  logic       finish_stb, abort_stb, fdc_reset_stb, irq_en, drive_sel, mode_ok, mode_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fdc_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .finish_stb(finish_stb), .abort_stb(abort_stb),
    .fdc_reset_stb(fdc_reset_stb), .irq_en(irq_en), .drive_sel(drive_sel),
    .mode_ok(mode_ok), .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobes packed as {finish, abort, reset}
  function automatic logic [7:0] stbs();
    return {5'b0, finish_stb, abort_stb, fdc_reset_stb};
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 strobes", stbs(), 8'h00);
    chk("R1 irq_en", {7'b0, irq_en}, 8'h00);
    chk("R1 drive_sel", {7'b0, drive_sel}, 8'h00);
    chk("R1 mode_ok", {7'b0, mode_ok}, 8'h00);
    chk("R1 mode_err", {7'b0, mode_err}, 8'h00);
    bus_read(2'd2, d); chk("R1 cmd read", d, 8'h00);
    bus_read(2'd3, d); chk("R1 mode read", d, 8'h00);
    bus_read(2'd0, d); chk("R11 bank A", d, 8'hE7);
    bus_read(2'd1, d); chk("R11 bank B", d, 8'hF8);
    addr = 2'd0; rd_en = 1'b0; #1 chk("R11 rd_en low", rdata, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_premode;
    logic [7:0] d;
    bus_write(2'd2, 8'h81);
    chk("R4 no strobe before mode", stbs(), 8'h00);
    bus_read(2'd2, d); chk("R4 cmd unchanged", d, 8'h00);
  endtask

  task automatic t_modes;
    logic [7:0] d;
    bus_write(2'd3, 8'h80);
    chk("R3 err set", {7'b0, mode_err}, 8'h01);
    chk("R3 mode_ok stays 0", {7'b0, mode_ok}, 8'h00);
    bus_read(2'd3, d); chk("R3 mode word kept", d, 8'h00);
    bus_write(2'd3, 8'h92);
    chk("R2 mode_ok", {7'b0, mode_ok}, 8'h01);
    chk("R2 err cleared", {7'b0, mode_err}, 8'h00);
    bus_read(2'd3, d); chk("R2 mode read", d, 8'h92);
    bus_write(2'd3, 8'h9A);
    chk("R3 err after good", {7'b0, mode_err}, 8'h01);
    chk("R3 mode_ok kept", {7'b0, mode_ok}, 8'h01);
    bus_read(2'd3, d); chk("R3 word kept 92", d, 8'h92);
    bus_write(2'd3, 8'h92);
    chk("R3 err cleared again", {7'b0, mode_err}, 8'h00);
  endtask

  task automatic t_finish;
    bus_write(2'd2, 8'h03);
    chk("R5 finish only", stbs(), 8'h04);
    @(negedge clk);
    chk("R5 one cycle wide", stbs(), 8'h00);
    addr = 2'd2; wdata = 8'h03; wr_en = 1'b1;
    @(negedge clk);
    chk("R5 back-to-back first", stbs(), 8'h04);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 back-to-back second", stbs(), 8'h04);
    @(negedge clk);
    chk("R5 ends", stbs(), 8'h00);
  endtask

  task automatic t_abort_reset;
    bus_write(2'd2, 8'h00);
    chk("R6 abort only", stbs(), 8'h02);
    bus_write(2'd2, 8'h02);
    chk("R6 ready high no abort", stbs(), 8'h00);
    bus_write(2'd2, 8'h82);
    chk("R7 reset only", stbs(), 8'h01);
    @(negedge clk);
    chk("R7 one cycle", stbs(), 8'h00);
  endtask

  task automatic t_irq;
    bus_write(2'd2, 8'h06);
    chk("R8 irq on", {7'b0, irq_en}, 8'h01);
    @(negedge clk);
    chk("R8 level held", {7'b0, irq_en}, 8'h01);
    bus_write(2'd2, 8'h02);
    chk("R8 irq off", {7'b0, irq_en}, 8'h00);
  endtask

  task automatic t_drive;
    bus_write(2'd2, 8'h02); chk("R9 both low -> 0", {7'b0, drive_sel}, 8'h00);
    bus_write(2'd2, 8'h0A); chk("R9 sel1 only -> 1", {7'b0, drive_sel}, 8'h01);
    bus_write(2'd2, 8'h1A); chk("R9 both high -> 0", {7'b0, drive_sel}, 8'h00);
    bus_write(2'd2, 8'h0A);
    bus_write(2'd2, 8'h12); chk("R9 sel0 only -> 0", {7'b0, drive_sel}, 8'h00);
  endtask

  task automatic t_store56;
    logic [7:0] d;
    bus_write(2'd2, 8'h0A);
    bus_write(2'd2, 8'h6A);
    chk("R10 no strobe", stbs(), 8'h00);
    chk("R10 drive unchanged", {7'b0, drive_sel}, 8'h01);
    chk("R10 irq unchanged", {7'b0, irq_en}, 8'h00);
    bus_read(2'd2, d); chk("R10 stored", d, 8'h6A);
  endtask

  task automatic t_ab_ignored;
    logic [7:0] d;
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h81);
    chk("R12 no strobe", stbs(), 8'h00);
    bus_read(2'd0, d); chk("R12 bank A", d, 8'hE7);
    bus_read(2'd1, d); chk("R12 bank B", d, 8'hF8);
    bus_read(2'd2, d); chk("R12 cmd kept", d, 8'h6A);
    bus_read(2'd3, d); chk("R12 mode kept", d, 8'h92);
    chk("R12 flags", {6'b0, mode_ok, mode_err}, 8'h02);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_premode;
    t_modes;
    t_finish;
    t_abort_reset;
    t_irq;
    t_drive;
    t_store56;
    t_ab_ignored;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule